// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory out of power-up before a memory controller takes over. A one-cycle start strobe arms it. It then waits out the power-up delay with CKE low and raises CKE. Next it drives the standard DDR2 start-up commands on a single-rate control output: precharge-all, the extended and main mode-register loads, two refreshes and off-chip-driver calibration entry and exit. Every wait is a whole number of clock cycles, derived from picosecond timing parameters and rounded up.

The mode-register contents are built from typed parameters: CAS latency (2 to 6), additive latency (0 to 4), write recovery, burst ordering, nominal termination (50, 75 or 150 ohms), drive strength and differential strobe enable. Burst length is always 8. After the registers are loaded and the DLL has had time to lock, the block issues three calibration reads on one command phase. It then raises a done flag that stays high until reset. A fast-simulation input shortens the long waits. A bypass parameter turns the block into a pass-through that issues nothing and reports done at once.

Top module: `ddr2_init_seq`

## Requirements
- R1: Until the start input has been sampled high, the block holds CKE low, drives CS# high (deselect), keeps done low and issues no command.
- R2: Commands are encoded on {CS#,RAS#,CAS#,WE#}: precharge 0010, refresh 0001, mode-register load 0000, read 0101, NOP 0111. The commands come in this order: precharge-all, load bank 2, load bank 3, load bank 1, load bank 0 with DLL reset, precharge-all, refresh, refresh, load bank 0, load bank 1 with calibration default, load bank 1 with calibration exit, then three reads to bank 0 at address 0.
- R3: Main mode-register word (bank 0) fields: A2:A0 = 011 (burst of 8); A3 = 0 for sequential or 1 for interleaved ordering; A6:A4 = CAS latency; A8 = 1 on the first load only (DLL reset); A11:A9 = write recovery minus 1. All other bits are 0.
- R4: Extended word (bank 1) fields: A0 = 0 (DLL on); A1 = 0 for full or 1 for reduced drive; termination on A6/A2 is 01 for 75, 10 for 150 and 11 for 50 ohms; A5:A3 = additive latency; A9:A7 = 111 for calibration default, else 000; A10 = 0 when the strobe is differential. The bank 2 and bank 3 words are all zero. A precharge-all has A10 = 1.
- R5: The next command follows a precharge ceil(tRPA/tCK) cycles later, a refresh ceil(tRFC/tCK) cycles later, and a mode-register load 2 cycles later.
- R6: CKE rises ceil(200 us / tCK) cycles after the start sample and the first precharge follows ceil(400 ns / tCK) cycles later; the first read follows the calibration exit by 200 cycles. With fast simulation selected these are 20, 8 and 16 cycles.
- R7: The second read follows the first by 4 cycles and the third follows by 8 more, so all reads sit on the same phase of a 4-cycle frame.
- R8: Done rises AL+CL+4 cycles after the third read, only after all three reads, and then stays high.
- R9: Once high, CKE never falls, and no command other than NOP or deselect is issued while CKE is low.
- R10: ODT is held low at all times.
- R11: With bypass set, done rises the cycle after the start sample, CKE stays low and CS# stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| fast_sim_i | input | 1 | Shortens the power-up, settle and DLL waits |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| bank_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode-register word |
| odt_o | output | 1 | On-die termination control |
| done_o | output | 1 | Initialization complete, sticky |

## Verification
Some properties are checked on every cycle: the quiet state before start, CKE never falling, no command while CKE is low, A10 set on every precharge, read phase alignment, and done rising only after the three reads and then staying high. Other results can only be shown by the bench's scenarios. These are the exact field encodings of each mode-register word, the rounded wait lengths between commands, and the long and short power-up waits. The bench covers them across two configurations, which differ in tCK, latencies, burst ordering, termination, drive and strobe, plus a bypass instance.

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq #(
  parameter int TCK_PS         = 8000,
  parameter int TRPA_PS        = 25000,
  parameter int TRFC_PS        = 327000,
  parameter int CAS_LAT        = 5,
  parameter int ADD_LAT        = 0,
  parameter int WR_REC         = 2,
  parameter int RTT_OHM        = 75,
  parameter bit SEQ_BURST      = 1'b1,
  parameter bit FULL_DRIVE     = 1'b1,
  parameter bit DIFF_STROBE    = 1'b1,
  parameter bit BYPASS         = 1'b0,
  parameter int PWRUP_PS       = 200_000_000,
  parameter int CKE_SETTLE_PS  = 400_000,
  parameter int TMRD_CYC       = 2,
  parameter int DLL_LOCK_CYC   = 200,
  parameter int SIM_PWRUP_CYC  = 20,
  parameter int SIM_SETTLE_CYC = 8,
  parameter int SIM_DLL_CYC    = 16,
  parameter int PHASES         = 4,
  parameter int ADDR_W         = 14,
  parameter int BA_W           = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              fast_sim_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              odt_o,
  output logic              done_o
);

  localparam int W_PWR = (PWRUP_PS + TCK_PS - 1) / TCK_PS;
  localparam int W_CKE = (CKE_SETTLE_PS + TCK_PS - 1) / TCK_PS;
  localparam int W_RP  = (TRPA_PS + TCK_PS - 1) / TCK_PS;
  localparam int W_RFC = (TRFC_PS + TCK_PS - 1) / TCK_PS;
  localparam int W_RDX = ADD_LAT + CAS_LAT + 4;
  localparam int CNT_W = $clog2(W_PWR + W_CKE + W_RFC + DLL_LOCK_CYC + 2*PHASES + W_RDX + 2);

  localparam logic [3:0] CMD_DES = 4'b1111;
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;
  localparam logic [3:0] CMD_RD  = 4'b0101;

  localparam logic [12:0] MR_WORD  = 13'((WR_REC - 1) << 9) | 13'(CAS_LAT << 4)
                                   | (SEQ_BURST ? 13'h000 : 13'h008) | 13'h003;
  localparam logic [12:0] RTT_BITS = (RTT_OHM == 50) ? 13'h044 :
                                     (RTT_OHM == 75) ? 13'h004 : 13'h040;
  localparam logic [12:0] EMR_WORD = (DIFF_STROBE ? 13'h000 : 13'h400) | 13'(ADD_LAT << 3)
                                   | RTT_BITS | (FULL_DRIVE ? 13'h000 : 13'h002);

  typedef enum logic [4:0] {
    S_IDLE, S_PWR, S_CKE, S_PRE1, S_EMR2, S_EMR3, S_EMR_DLL, S_MR_RST, S_PRE2,
    S_REF1, S_REF2, S_MR, S_OCD_DEF, S_OCD_EXIT, S_RD0, S_RD1, S_RD2, S_DONE
  } step_t;

  step_t            st, nxt;
  logic [CNT_W-1:0] cnt;
  logic             first;
  logic [3:0]       cmd;
  logic [BA_W-1:0]  ba;
  logic [12:0]      a;

  function automatic logic [CNT_W-1:0] wait_of(step_t s, logic fast);
    int w;
    case (s)
      S_PWR:            w = fast ? SIM_PWRUP_CYC : W_PWR;
      S_CKE:            w = fast ? SIM_SETTLE_CYC : W_CKE;
      S_PRE1, S_PRE2:   w = W_RP;
      S_REF1, S_REF2:   w = W_RFC;
      S_OCD_EXIT:       w = fast ? SIM_DLL_CYC : DLL_LOCK_CYC;
      S_RD0:            w = PHASES;
      S_RD1:            w = 2 * PHASES;
      S_RD2:            w = W_RDX;
      default:          w = TMRD_CYC;
    endcase
    return CNT_W'(w);
  endfunction

  assign nxt = step_t'(st + 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      first <= 1'b0;
    end else begin
      first <= 1'b0;
      if (st == S_IDLE) begin
        if (start_i) begin
          st    <= BYPASS ? S_DONE : S_PWR;
          cnt   <= wait_of(S_PWR, fast_sim_i) - 1'b1;
          first <= 1'b1;
        end
      end else if (st != S_DONE) begin
        if (cnt == '0) begin
          st    <= nxt;
          cnt   <= wait_of(nxt, fast_sim_i) - 1'b1;
          first <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd = (st == S_IDLE || BYPASS) ? CMD_DES : CMD_NOP;
    ba  = '0;
    a   = '0;
    if (first && !BYPASS) begin
      case (st)
        S_PRE1, S_PRE2: begin cmd = CMD_PRE; a = 13'h400; end
        S_EMR2:         begin cmd = CMD_MRS; ba = BA_W'(2); end
        S_EMR3:         begin cmd = CMD_MRS; ba = BA_W'(3); end
        S_EMR_DLL:      begin cmd = CMD_MRS; ba = BA_W'(1); a = EMR_WORD; end
        S_MR_RST:       begin cmd = CMD_MRS; a = MR_WORD | 13'h100; end
        S_REF1, S_REF2: cmd = CMD_REF;
        S_MR:           begin cmd = CMD_MRS; a = MR_WORD; end
        S_OCD_DEF:      begin cmd = CMD_MRS; ba = BA_W'(1); a = EMR_WORD | 13'h380; end
        S_OCD_EXIT:     begin cmd = CMD_MRS; ba = BA_W'(1); a = EMR_WORD; end
        S_RD0, S_RD1, S_RD2: cmd = CMD_RD;
        default: ;
      endcase
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
  assign bank_o = ba;
  assign addr_o = ADDR_W'(a);
  assign cke_o  = !BYPASS && st != S_IDLE && st != S_PWR;
  assign odt_o  = 1'b0;
  assign done_o = (st == S_DONE);

endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
  parameter bit BYPASS = 1'b0,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              cke_o,
  input logic              cs_n_o,
  input logic              ras_n_o,
  input logic              cas_n_o,
  input logic              we_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);

  logic       seen, had_rd;
  logic [7:0] gap;
  logic [1:0] rdn;
  logic       is_rd, is_pre, is_cmd;

  assign is_rd  = !cs_n_o && ras_n_o && !cas_n_o && we_n_o;
  assign is_pre = !cs_n_o && !ras_n_o && cas_n_o && !we_n_o;
  assign is_cmd = !cs_n_o && !(ras_n_o && cas_n_o && we_n_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; had_rd <= 1'b0; gap <= '0; rdn <= '0;
    end else begin
      if (start_i) seen <= 1'b1;
      if (is_rd) begin
        had_rd <= 1'b1;
        gap    <= 8'd1;
        if (rdn != 2'd3) rdn <= rdn + 2'd1;
      end else if (gap != 8'hff) begin
        gap <= gap + 8'd1;
      end
    end
  end

  p_quiet_before_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (cs_n_o && !cke_o && !done_o));

  p_precharge_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> addr_o[10]);

  p_read_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && had_rd) |-> (gap[1:0] == 2'b00));

  p_done_after_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (rdn == (BYPASS ? 2'd0 : 2'd3)));

  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  p_cke_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  p_cmd_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> cke_o);

endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(.BYPASS(BYPASS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ddr2_init_seq.sv
module sim_ddr2_init_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  cmdv [3];
  logic [2:0]  bav  [3];
  logic [13:0] adv  [3];
  logic        ckev [3];
  logic        donev[3];
  logic        odtv [3];

  ddr2_init_seq u0 (.clk(clk), .rst_n(rst_n), .start_i(start), .fast_sim_i(1'b1),
    .cke_o(ckev[0]), .cs_n_o(cmdv[0][3]), .ras_n_o(cmdv[0][2]), .cas_n_o(cmdv[0][1]),
    .we_n_o(cmdv[0][0]), .bank_o(bav[0]), .addr_o(adv[0]), .odt_o(odtv[0]), .done_o(donev[0]));

  ddr2_init_seq #(.TCK_PS(5000), .CAS_LAT(2), .ADD_LAT(4), .WR_REC(3), .RTT_OHM(50),
    .SEQ_BURST(1'b0), .FULL_DRIVE(1'b0), .DIFF_STROBE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .fast_sim_i(1'b0),
    .cke_o(ckev[1]), .cs_n_o(cmdv[1][3]), .ras_n_o(cmdv[1][2]), .cas_n_o(cmdv[1][1]),
    .we_n_o(cmdv[1][0]), .bank_o(bav[1]), .addr_o(adv[1]), .odt_o(odtv[1]), .done_o(donev[1]));

  ddr2_init_seq #(.BYPASS(1'b1)) u2 (.clk(clk), .rst_n(rst_n), .start_i(start), .fast_sim_i(1'b1),
    .cke_o(ckev[2]), .cs_n_o(cmdv[2][3]), .ras_n_o(cmdv[2][2]), .cas_n_o(cmdv[2][1]),
    .we_n_o(cmdv[2][0]), .bank_o(bav[2]), .addr_o(adv[2]), .odt_o(odtv[2]), .done_o(donev[2]));

  int          n     [2];
  int          t     [2][32];
  logic [3:0]  lc    [2][32];
  logic [2:0]  lb    [2][32];
  logic [13:0] la    [2][32];
  int          cke_t [2];
  int          done_t[2];
  int          odt_hi = 0;
  int          cke_bad = 0;
  int          byp_bad = 0;
  bit          logging = 1'b0;

  always @(negedge clk) begin
    if (logging) begin
      for (int i = 0; i < 2; i++) begin
        if (cmdv[i] != 4'b0111 && cmdv[i] != 4'b1111 && n[i] < 32) begin
          t[i][n[i]] = cyc; lc[i][n[i]] = cmdv[i]; lb[i][n[i]] = bav[i]; la[i][n[i]] = adv[i];
          n[i] = n[i] + 1;
        end
        if (ckev[i] && cke_t[i] < 0) cke_t[i] = cyc;
        if (!ckev[i] && cke_t[i] >= 0) cke_bad++;
        if (donev[i] && done_t[i] < 0) done_t[i] = cyc;
      end
      if (ckev[2] || !cmdv[2][3]) byp_bad++;
    end
    for (int i = 0; i < 3; i++) if (odtv[i]) odt_hi++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [13:0] mrw(int cl, int bt, int wr, int rst);
    return 14'(((wr - 1) << 9) | (rst << 8) | (cl << 4) | (bt << 3) | 3);
  endfunction

  function automatic logic [13:0] emrw(int al, int rtt, int full, int diff, int ocd);
    int r;
    r = (rtt == 50) ? 'h44 : (rtt == 75) ? 'h04 : 'h40;
    return 14'(((diff ? 0 : 1) << 10) | (ocd << 7) | r | (al << 3) | ((full ? 0 : 1) << 1));
  endfunction

  int start_cyc;

  initial begin
    cke_t = '{-1, -1};
    done_t = '{-1, -1};
    n = '{0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++)
        chk($sformatf("R1 idle inst%0d", i), {ckev[i], cmdv[i][3], donev[i]}, 3'b010);
    end
    start = 1'b1; start_cyc = cyc; logging = 1'b1;
    chk("R11 done low at start", donev[2], 1'b0);
    @(negedge clk);
    start = 1'b0;
    chk("R11 bypass done next cycle", donev[2], 1'b1);
    while (!(donev[0] && donev[1]) && cyc < start_cyc + 150000) @(negedge clk);
    if (!(donev[0] && donev[1])) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=%0d expected=done", cyc);
    end
    repeat (5) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      int tck, cl, al, wr, bt, rtt, full, diff, fast, wp, wc, rp, rfc, dll;
      tck = i ? 5000 : 8000; cl = i ? 2 : 5; al = i ? 4 : 0; wr = i ? 3 : 2;
      bt = i ? 1 : 0; rtt = i ? 50 : 75; full = i ? 0 : 1; diff = i ? 0 : 1; fast = i ? 0 : 1;
      wp  = fast ? 20 : (200000000 + tck - 1) / tck;
      wc  = fast ? 8 : (400000 + tck - 1) / tck;
      rp  = (25000 + tck - 1) / tck;
      rfc = (327000 + tck - 1) / tck;
      dll = fast ? 16 : 200;
      chk($sformatf("R6 inst%0d cke rise", i), cke_t[i] - start_cyc, 1 + wp);
      chk($sformatf("R2 inst%0d command count", i), n[i], 14);
      if (n[i] == 14) begin
        chk($sformatf("R6 inst%0d settle", i), t[i][0] - cke_t[i], wc);
        for (int k = 0; k < 14; k++) begin
          logic [3:0] ec; logic [2:0] eb; logic [13:0] ea; int eg, ag; string tg;
          eb = 0; ea = 0; ec = 4'b0000; tg = "R2";
          case (k)
            0, 5:  begin ec = 4'b0010; ea = 14'h400; eg = rp; tg = "R5"; end
            1:     begin eb = 2; eg = 2; tg = "R4"; end
            2:     begin eb = 3; eg = 2; tg = "R4"; end
            3:     begin eb = 1; ea = emrw(al, rtt, full, diff, 0); eg = 2; tg = "R4"; end
            4:     begin ea = mrw(cl, bt, wr, 1); eg = 2; tg = "R3"; end
            6, 7:  begin ec = 4'b0001; eg = rfc; tg = "R5"; end
            8:     begin ea = mrw(cl, bt, wr, 0); eg = 2; tg = "R3"; end
            9:     begin eb = 1; ea = emrw(al, rtt, full, diff, 7); eg = 2; tg = "R4"; end
            10:    begin eb = 1; ea = emrw(al, rtt, full, diff, 0); eg = dll; tg = "R6"; end
            11:    begin ec = 4'b0101; eg = 4; tg = "R7"; end
            12:    begin ec = 4'b0101; eg = 8; tg = "R7"; end
            default: begin ec = 4'b0101; eg = al + cl + 4; tg = "R8"; end
          endcase
          ag = (k < 13) ? t[i][k+1] - t[i][k] : done_t[i] - t[i][k];
          chk($sformatf("R2 inst%0d step%0d cmd", i, k), lc[i][k], ec);
          chk($sformatf("%s inst%0d step%0d field", tg, i, k), {lb[i][k], la[i][k]}, {eb, ea});
          chk($sformatf("%s inst%0d step%0d gap", tg, i, k), ag, eg);
        end
      end
      chk($sformatf("R8 inst%0d done sticky", i), donev[i], 1'b1);
    end
    chk("R9 cke never fell", cke_bad, 0);
    chk("R10 odt never high", odt_hi, 0);
    chk("R11 bypass quiet", byp_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule